// File: doc/BRIEF.md
# Video Timing-Reference Checker

This block watches a stream of 10-bit video words and picks out the timing-reference sequences that mark the start and the end of active video on each line. Each sequence is a three-word preamble followed by a flag word that carries the field, vertical-blank and horizontal flags plus four protection bits. The block checks two things for every such flag word. The first is that its protection bits agree with its flags. The second is that it arrives in the same cycle as the matching position pulse from an external line-timing flywheel.

Start-of-active-video errors and end-of-active-video errors are latched into two separate sticky flags, and a clear input resets both. Timing comparison against the flywheel is active only while the flywheel-enable input is high, but protection errors are always reported. In the high-definition multiplexed format, where chroma and luma words alternate, only the luma words are examined.

Top module: `trs_checker`

## Requirements
- R1: While `rst` is high at a clock edge, both `sav_err` and `eav_err` are 0 after that edge.
- R2: A preamble is a channel word whose bits 9:2 are all ones, followed by two channel words whose bits 9:2 are all zeros, so bits 1:0 are ignored and both the 10-bit (3FF, 000, 000) and 8-bit forms are accepted. The next channel word after a preamble is the flag word, whatever its value. A preamble broken by any other channel word is not recognised.
- R3: In the flag word, bit 8 is F, bit 7 is V and bit 6 is H. The word is well protected only if bit 9 is 1 and bits 5, 4, 3 and 2 equal V^H, F^H, F^V and F^V^H. A badly protected flag word sets `sav_err` when H is 0 and `eav_err` when H is 1.
- R4: While `fw_en` is high, a flag word with H=0 that arrives on a channel word without `fw_sav` sets `sav_err`, and `fw_sav` on a channel word that is not such a flag word also sets `sav_err`. `fw_eav` and flag words with H=1 set `eav_err` in the same way.
- R5: While `fw_en` is low, no timing error is reported, but protection errors still set the flags.
- R6: When `hd_mode` is 0, every valid word is a channel word. When `hd_mode` is 1, valid words alternate chroma then luma, starting with chroma at the first valid word after reset. Only luma words are channel words. Chroma words, and flywheel pulses that arrive with them, have no effect.
- R7: A cycle with `word_vld` low has no effect: its word and pulses are ignored, and preamble tracking continues across it.
- R8: Both flags are sticky and change one clock edge after the word that causes them. `err_clr` clears both flags at the next edge, but an error detected in the same cycle as `err_clr` still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 10 | Video word |
| word_vld | input | 1 | Qualifies `word_in` and the flywheel pulses |
| fw_sav | input | 1 | Flywheel says this word is the start-of-video flag word |
| fw_eav | input | 1 | Flywheel says this word is the end-of-video flag word |
| fw_en | input | 1 | Enables the timing comparison |
| hd_mode | input | 1 | 1: chroma/luma multiplexed, luma only checked; 0: single stream |
| err_clr | input | 1 | Clears both sticky flags |
| sav_err | output | 1 | Sticky start-of-video error |
| eav_err | output | 1 | Sticky end-of-video error |

## Verification
The bench sends preambles broken by a stray word, which a detector that does not restart its match would take as valid. It sends 8-bit preambles with non-zero low bits, which a design comparing all ten bits would miss. It also sends gaps with `word_vld` low that carry junk words and pulses in the middle of a preamble, and in the multiplexed mode it sends bad or mistimed sequences on chroma words only. A design that reports those as errors fails. It also checks protection errors with the flywheel disabled, flags raised by pulses that arrive with no sequence, and an error raised in the same cycle as a clear, where a clear-wins design would drop the flag.

// File: rtl/trs_pkg.sv
package trs_pkg;

    localparam int TRS_W    = 10;
    localparam int TAG_LSB  = 2;   // bits below this are ignored in the preamble
    localparam int BIT_ONE  = 9;
    localparam int BIT_F    = 8;
    localparam int BIT_V    = 7;
    localparam int BIT_H    = 6;
    localparam int PROT_MSB = 5;
    localparam int PROT_W   = 4;
    localparam int PROT_LSB = PROT_MSB - PROT_W + 1;

    localparam int KIND_SAV = 0;
    localparam int KIND_EAV = 1;
    localparam int N_KIND   = 2;

    typedef logic [TRS_W-1:0] word_t;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_ONES,
        PS_ZERO1,
        PS_ZERO2
    } pre_state_e;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } fvh_t;

    typedef struct packed {
        logic hit;
        logic is_eav;
        logic prot_bad;
    } xyz_evt_t;

    function automatic logic is_ones(input word_t w);
        return &w[TRS_W-1:TAG_LSB];
    endfunction

    function automatic logic is_zeros(input word_t w);
        return ~|w[TRS_W-1:TAG_LSB];
    endfunction

    function automatic fvh_t get_fvh(input word_t w);
        fvh_t r;
        r.f = w[BIT_F];
        r.v = w[BIT_V];
        r.h = w[BIT_H];
        return r;
    endfunction

    function automatic logic [PROT_W-1:0] prot_of(input fvh_t x);
        return {x.v ^ x.h, x.f ^ x.h, x.f ^ x.v, x.f ^ x.v ^ x.h};
    endfunction

    function automatic logic xyz_bad(input word_t w);
        return !w[BIT_ONE] || (w[PROT_MSB:PROT_LSB] != prot_of(get_fvh(w)));
    endfunction

endpackage

// File: rtl/trs_chan_sel.sv
module trs_chan_sel
    import trs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic word_vld,
    input  logic hd_mode,
    output logic chan_vld
);

    logic phase_q;   // 0: chroma slot, 1: luma slot

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
        end else if (word_vld) begin
            phase_q <= ~phase_q;
        end
    end

    always_comb begin
        chan_vld = word_vld && (!hd_mode || phase_q);
    end

endmodule

// File: rtl/trs_preamble_det.sv
module trs_preamble_det
    import trs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     chan_vld,
    input  word_t    word_in,
    output xyz_evt_t evt
);

    pre_state_e state_q, state_d;
    logic       w_ones, w_zero;
    logic       unused_low;

    assign unused_low = ^word_in[TAG_LSB-1:0];

    always_comb begin
        w_ones  = is_ones(word_in);
        w_zero  = is_zeros(word_in);
        state_d = state_q;
        if (chan_vld) begin
            if (state_q == PS_ZERO2) begin
                state_d = w_ones ? PS_ONES : PS_IDLE;
            end else if (w_ones) begin
                state_d = PS_ONES;
            end else if (w_zero && state_q == PS_ONES) begin
                state_d = PS_ZERO1;
            end else if (w_zero && state_q == PS_ZERO1) begin
                state_d = PS_ZERO2;
            end else begin
                state_d = PS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        evt.hit      = chan_vld && (state_q == PS_ZERO2);
        evt.is_eav   = get_fvh(word_in).h;
        evt.prot_bad = xyz_bad(word_in);
    end

endmodule

// File: rtl/trs_err_judge.sv
module trs_err_judge
    import trs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_vld,
    input  xyz_evt_t          evt,
    input  logic [N_KIND-1:0] fw_pulse,
    input  logic              fw_en,
    input  logic              err_clr,
    output logic [N_KIND-1:0] err_q
);

    for (genvar k = 0; k < N_KIND; k++) begin : g_kind
        logic kind_hit;
        logic pulse_ok;
        logic new_err;

        always_comb begin
            kind_hit = evt.hit && (evt.is_eav == (k == KIND_EAV));
            pulse_ok = chan_vld && fw_pulse[k];
            new_err  = (kind_hit && evt.prot_bad)
                     || (fw_en && (kind_hit != pulse_ok));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                err_q[k] <= 1'b0;
            end else begin
                err_q[k] <= (err_q[k] && !err_clr) || new_err;
            end
        end
    end

endmodule

// File: rtl/trs_checker.sv
module trs_checker
    import trs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [TRS_W-1:0] word_in,
    input  logic             word_vld,
    input  logic             fw_sav,
    input  logic             fw_eav,
    input  logic             fw_en,
    input  logic             hd_mode,
    input  logic             err_clr,
    output logic             sav_err,
    output logic             eav_err
);

    logic              chan_vld;
    xyz_evt_t          det_evt;
    logic [N_KIND-1:0] pulses;
    logic [N_KIND-1:0] flags;

    always_comb begin
        pulses           = '0;
        pulses[KIND_SAV] = fw_sav;
        pulses[KIND_EAV] = fw_eav;
    end

    trs_chan_sel u_sel (
        .clk      (clk),
        .rst      (rst),
        .word_vld (word_vld),
        .hd_mode  (hd_mode),
        .chan_vld (chan_vld)
    );

    trs_preamble_det u_det (
        .clk      (clk),
        .rst      (rst),
        .chan_vld (chan_vld),
        .word_in  (word_in),
        .evt      (det_evt)
    );

    trs_err_judge u_judge (
        .clk      (clk),
        .rst      (rst),
        .chan_vld (chan_vld),
        .evt      (det_evt),
        .fw_pulse (pulses),
        .fw_en    (fw_en),
        .err_clr  (err_clr),
        .err_q    (flags)
    );

    assign sav_err = flags[KIND_SAV];
    assign eav_err = flags[KIND_EAV];

endmodule

// File: rtl/trs_checker_sva.sv
module trs_checker_sva
    import trs_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     word_vld,
    input logic     hd_mode,
    input logic     fw_en,
    input logic     err_clr,
    input logic     chan_vld,
    input xyz_evt_t det_evt,
    input logic     sav_err,
    input logic     eav_err
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!sav_err && !eav_err));

    a_r8_sticky_sav: assert property (@(posedge clk) disable iff (rst)
        (sav_err && !err_clr) |=> sav_err);

    a_r8_sticky_eav: assert property (@(posedge clk) disable iff (rst)
        (eav_err && !err_clr) |=> eav_err);

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!word_vld && !err_clr) |=> ($stable(sav_err) && $stable(eav_err)));

    a_r6_chroma_ignored: assert property (@(posedge clk) disable iff (rst)
        (word_vld && hd_mode && !chan_vld && !err_clr)
            |=> ($stable(sav_err) && $stable(eav_err)));

    a_r5_sav_only_prot: assert property (@(posedge clk) disable iff (rst)
        (!fw_en && !sav_err && !(det_evt.hit && !det_evt.is_eav && det_evt.prot_bad))
            |=> !sav_err);

    a_r5_eav_only_prot: assert property (@(posedge clk) disable iff (rst)
        (!fw_en && !eav_err && !(det_evt.hit && det_evt.is_eav && det_evt.prot_bad))
            |=> !eav_err);

endmodule

bind trs_checker trs_checker_sva u_sva (
    .clk      (clk),
    .rst      (rst),
    .word_vld (word_vld),
    .hd_mode  (hd_mode),
    .fw_en    (fw_en),
    .err_clr  (err_clr),
    .chan_vld (chan_vld),
    .det_evt  (det_evt),
    .sav_err  (sav_err),
    .eav_err  (eav_err)
);

// File: tb/trs_checker_bench.sv
module trs_checker_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] word_in = '0;
    logic       word_vld = 1'b0;
    logic       fw_sav = 1'b0;
    logic       fw_eav = 1'b0;
    logic       fw_en = 1'b1;
    logic       hd_mode = 1'b0;
    logic       err_clr = 1'b0;
    logic       sav_err, eav_err;

    int    n_tests = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    int hist[$];
    int vcount = 0;
    bit exp_sav = 0;
    bit exp_eav = 0;

    always #2 clk = ~clk;   // 250 MHz

    trs_checker u_trs_checker (
        .clk(clk), .rst(rst), .word_in(word_in), .word_vld(word_vld),
        .fw_sav(fw_sav), .fw_eav(fw_eav), .fw_en(fw_en), .hd_mode(hd_mode),
        .err_clr(err_clr), .sav_err(sav_err), .eav_err(eav_err)
    );

    function automatic logic [9:0] mk_xyz(bit f, bit v, bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

    function automatic bit top_ones(int w);
        return ((w >> 2) & 8'hFF) == 8'hFF;
    endfunction

    function automatic bit top_zero(int w);
        return ((w >> 2) & 8'hFF) == 0;
    endfunction

    // compare previous expectation, then drive one cycle and advance the model
    task automatic tick(bit vld, logic [9:0] w, bit sp, bit ep, bit clr);
        bit chan, hit, bad, f, v, h;
        @(negedge clk);
        n_tests++;
        if (sav_err !== exp_sav || eav_err !== exp_eav) begin
            n_fail++;
            $display("FAIL %s: sav/eav actual=%b%b expected=%b%b at %0t",
                     cur_req, sav_err, eav_err, exp_sav, exp_eav, $time);
        end
        word_vld = vld; word_in = w; fw_sav = sp; fw_eav = ep; err_clr = clr;
        if (rst) begin
            hist.delete(); vcount = 0; exp_sav = 0; exp_eav = 0;
            return;
        end
        chan = vld && (!hd_mode || (vcount % 2 == 1));
        if (vld) vcount++;
        hit = 0;
        if (chan) begin
            if (hist.size() == 3 && top_ones(hist[0]) && top_zero(hist[1]) && top_zero(hist[2]))
                hit = 1;
            hist.push_back(int'(w));
            if (hist.size() > 3) void'(hist.pop_front());
        end
        f = w[8]; v = w[7]; h = w[6];
        bad = !w[9] || (w[5] != (v ^ h)) || (w[4] != (f ^ h)) || (w[3] != (f ^ v)) || (w[2] != (f ^ v ^ h));
        exp_sav = (exp_sav && !clr) || (hit && !h && bad) || (fw_en && ((hit && !h) != (chan && sp)));
        exp_eav = (exp_eav && !clr) || (hit && h && bad) || (fw_en && ((hit && h) != (chan && ep)));
    endtask

    task automatic vw(logic [9:0] w, bit sp = 0, bit ep = 0);
        tick(1, w, sp, ep, 0);
    endtask

    task automatic clear();
        tick(1, 10'h200, 0, 0, 1);
        tick(1, 10'h200, 0, 0, 0);
    endtask

    task automatic trs(logic [9:0] x, bit sp, bit ep);
        vw(10'h3FF); vw(10'h000); vw(10'h000); vw(x, sp, ep);
    endtask

    task automatic hd_pair(logic [9:0] c, logic [9:0] y, bit csp, bit ysp, bit yep);
        vw(c, csp, 0);
        vw(y, ysp, yep);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL R8: watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (3) tick(0, 0, 0, 0, 0);
        rst = 1'b0;
        tick(0, 0, 0, 0, 0);

        // R2/R4: well-formed, well-timed 10-bit and 8-bit sequences
        cur_req = "R2";
        trs(mk_xyz(0, 0, 0), 1, 0); repeat (3) vw(10'h200);
        trs(mk_xyz(0, 0, 1), 0, 1); vw(10'h040);
        vw(10'h3FD); vw(10'h002); vw(10'h001); vw(mk_xyz(1, 1, 0) | 10'h1, 1, 0);
        vw(10'h3FC); vw(10'h003); vw(10'h000); vw(mk_xyz(1, 0, 1) | 10'h2, 0, 1);
        vw(10'h200);
        // broken preamble: pulse lands on an unrecognised word
        vw(10'h3FF); vw(10'h000); vw(10'h200); vw(10'h000); vw(mk_xyz(0, 1, 0), 1, 0);
        vw(10'h200); clear();

        // R3: protection errors, routed by H
        cur_req = "R3";
        trs(mk_xyz(1, 0, 0) ^ 10'h004, 1, 0); vw(10'h200); clear();
        trs(mk_xyz(0, 1, 1) ^ 10'h020, 0, 1); vw(10'h200); clear();
        trs(mk_xyz(0, 0, 0) & 10'h1FF, 1, 0); vw(10'h200); clear();

        // R4: timing mismatch both ways, both kinds
        cur_req = "R4";
        trs(mk_xyz(0, 0, 0), 0, 0); vw(10'h200); clear();
        vw(10'h200, 1, 0); vw(10'h200); clear();
        trs(mk_xyz(0, 0, 1), 0, 0); vw(10'h200); clear();
        vw(10'h200, 0, 1); vw(10'h200); clear();
        trs(mk_xyz(0, 0, 1), 1, 0); vw(10'h200); clear();

        // R5: flywheel disabled
        cur_req = "R5";
        fw_en = 1'b0;
        trs(mk_xyz(0, 0, 0), 0, 0); vw(10'h200, 1, 1); vw(10'h200);
        trs(mk_xyz(1, 1, 1) ^ 10'h008, 0, 0); vw(10'h200); clear();
        fw_en = 1'b1;

        // R7: invalid cycles inside a preamble carry junk and pulses
        cur_req = "R7";
        vw(10'h3FF); tick(0, 10'h155, 1, 1, 0); vw(10'h000);
        tick(0, 10'h3FF, 1, 0, 0); tick(0, 10'h000, 0, 1, 0);
        vw(10'h000); vw(mk_xyz(0, 1, 0), 1, 0); vw(10'h200);

        // R8: error in the clear cycle wins, then stays
        cur_req = "R8";
        vw(10'h3FF); vw(10'h000); vw(10'h000);
        tick(1, mk_xyz(0, 0, 0) ^ 10'h010, 1, 0, 1);
        repeat (4) vw(10'h200);
        tick(0, 10'h000, 0, 0, 0);
        clear();

        // R6: multiplexed mode, only luma words count
        cur_req = "R6";
        hd_mode = 1'b1;
        if (vcount % 2 == 1) vw(10'h040);
        hd_pair(10'h3FF, 10'h040, 0, 0, 0);
        hd_pair(10'h000, 10'h040, 0, 0, 0);
        hd_pair(10'h000, 10'h040, 0, 0, 0);
        hd_pair(mk_xyz(0, 0, 0) ^ 10'h004, 10'h040, 1, 0, 0);
        hd_pair(10'h200, 10'h040, 0, 0, 0);
        hd_pair(10'h3FF, 10'h3FF, 0, 0, 0);
        hd_pair(10'h000, 10'h000, 0, 0, 0);
        hd_pair(10'h000, 10'h000, 0, 0, 0);
        hd_pair(mk_xyz(0, 0, 0), mk_xyz(0, 0, 0), 0, 1, 0);
        hd_pair(10'h200, 10'h040, 0, 0, 0);
        hd_pair(10'h3FF, 10'h3FF, 0, 0, 0);
        hd_pair(10'h000, 10'h000, 0, 0, 0);
        hd_pair(10'h000, 10'h000, 0, 0, 0);
        hd_pair(mk_xyz(0, 0, 1), mk_xyz(1, 0, 1) ^ 10'h004, 0, 0, 1);
        hd_pair(10'h200, 10'h040, 0, 0, 0);
        clear();
        hd_mode = 1'b0;
        repeat (2) vw(10'h200);
        tick(1, 10'h200, 0, 0, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule